// File: doc/BRIEF.md
# Quarter-Wave Sine Sample Generator

This block produces a periodic stream of unsigned 8-bit sine samples. The rise from the midline to the positive peak is the only part held in a lookup table. The falling half of the positive lobe comes from reading that table backwards. The negative lobe comes from subtracting the positive-lobe value from full scale. A 5-bit phase accumulator moves forward by a programmable step on each enabled clock, so the output frequency is the clock rate times the step divided by 32.

The table has nine entries, from the midline value 128 up to the peak value 255. The two most significant phase bits choose the lobe and the reading direction. The three low phase bits give the position within the quarter. Each enabled cycle registers one sample and raises a valid strobe that lines up with the new sample.

Top module: `sine_quarter_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the phase is cleared to 0, `sampleOut` becomes 128 and `sampleValid` becomes 0. The first enabled cycle after reset outputs the sample for phase 0, which is 128.
- R2: `sampleValid` is high in exactly the cycles that follow a clock edge where `enable` was high and `rst` was low.
- R3: On an edge where `enable` is low, both `sampleOut` and the phase keep their values. The next enabled sample continues the sequence from where it stopped.
- R4: On each enabled edge, the phase advances by `stepSize` modulo 32. The sample registered on that edge belongs to the phase value from before the advance.
- R5: For phase k from 0 to 7 the sample is Q[k], where Q = 128, 152, 176, 198, 218, 234, 245, 253, 255 (indices 0 to 8).
- R6: For phase k from 8 to 15 the sample is Q[8 - (k mod 8)]. Phase 8 gives the 255 peak and phase 15 gives 152.
- R7: For phase k from 17 to 31 the sample is 255 minus the sample of phase k-16. For example, phase 24 gives 0 and phase 31 gives 103.
- R8: Phase 16 gives the midline value 128. It does not give 127.
- R9: With `stepSize` 0 held over consecutive enabled cycles, `sampleOut` stays constant.
- R10: With `stepSize` 1, the output sequence repeats every 32 samples: sample n equals sample n+32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Produces a sample and advances the phase on this edge |
| stepSize | input | 5 | Phase increment per enabled cycle |
| sampleOut | output | 8 | Registered unsigned sine sample |
| sampleValid | output | 1 | High in the cycle a new sample appears |

## Verification
The bench builds the block with its default widths: a 5-bit phase and 8-bit samples. This makes every one of the 32 phase points, and every step value from 0 to 31, reachable in a short run. With steps 1, 3, 8, 31 and 5, the phase wraps and lands on each quadrant boundary: 8, 16 and 24. That exercises both the folding seams and the forced midline at phase 16. Idle gaps, a zero step and a reset in the middle of a sweep check that the phase stops and restarts correctly.

// File: rtl/sinegen_pkg.sv
package sinegen_pkg;

  // Phase accumulator width; the period is 2**PHASE_W points
  localparam int PHASE_W  = 5;
  // Unsigned sample width
  localparam int SAMPLE_W = 8;
  // Address bits inside one quadrant
  localparam int QADDR_W  = PHASE_W - 2;
  // Stored entries: one quadrant plus the peak point
  localparam int QDEPTH   = (1 << QADDR_W) + 1;
  // Width needed to address QDEPTH entries
  localparam int ROMA_W   = QADDR_W + 1;
  localparam logic [SAMPLE_W-1:0] MIDLINE   = SAMPLE_W'(1 << (SAMPLE_W - 1));
  localparam logic [SAMPLE_W-1:0] FULLSCALE = {SAMPLE_W{1'b1}};
  localparam logic [PHASE_W-1:0]  HALFPHASE = PHASE_W'(1 << (PHASE_W - 1));

  // Strobes from control to datapath
  typedef struct packed {
    logic               load;      // register a new sample
    logic               reverse;   // read the quadrant backwards
    logic               invert;    // negative lobe
    logic               forceMid;  // exact half-period point
    logic [QADDR_W-1:0] fineIdx;   // position within the quadrant
  } foldCtrl_t;

  // Rising quarter of the wave, midline to peak
  function automatic logic [SAMPLE_W-1:0] quarterValue(input int idx);
    logic [SAMPLE_W-1:0] v;
    case (idx)
      0:       v = 8'd128;
      1:       v = 8'd152;
      2:       v = 8'd176;
      3:       v = 8'd198;
      4:       v = 8'd218;
      5:       v = 8'd234;
      6:       v = 8'd245;
      7:       v = 8'd253;
      default: v = 8'd255;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/sinegen_qrom.sv
module sinegen_qrom
  import sinegen_pkg::*;
(
  input  logic [ROMA_W-1:0]   romAddr,
  output logic [SAMPLE_W-1:0] romData
);

  logic [SAMPLE_W-1:0] romTable [QDEPTH];

  // Fill the quadrant table entry by entry
  for (genvar g = 0; g < QDEPTH; g++) begin : g_entry
    assign romTable[g] = quarterValue(g);
  end

  // Addresses past the last entry return the peak
  always_comb begin
    if (int'(romAddr) < QDEPTH) romData = romTable[romAddr];
    else                        romData = romTable[QDEPTH-1];
  end

endmodule

// File: rtl/sinegen_ctrl.sv
module sinegen_ctrl
  import sinegen_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic [PHASE_W-1:0] stepSize,
  output foldCtrl_t          foldCtrl,
  output logic               sampleValid
);

  logic [PHASE_W-1:0] phaseAcc;

  // Phase accumulator wraps naturally at its width
  always_ff @(posedge clk) begin
    if (rst) begin
      phaseAcc    <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= enable;
      if (enable) phaseAcc <= phaseAcc + stepSize;
    end
  end

  // Decode the current phase into folding strobes
  always_comb begin
    foldCtrl.load     = enable & ~rst;
    foldCtrl.invert   = phaseAcc[PHASE_W-1];
    foldCtrl.reverse  = phaseAcc[PHASE_W-2];
    foldCtrl.forceMid = (phaseAcc == HALFPHASE);
    foldCtrl.fineIdx  = phaseAcc[QADDR_W-1:0];
  end

endmodule

// File: rtl/sinegen_dpath.sv
module sinegen_dpath
  import sinegen_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  foldCtrl_t           foldCtrl,
  output logic [SAMPLE_W-1:0] sampleOut
);

  logic [ROMA_W-1:0]   romAddr;
  logic [SAMPLE_W-1:0] romData;
  logic [SAMPLE_W-1:0] foldedVal;

  // Mirror the address in the falling part of each lobe
  always_comb begin
    if (foldCtrl.reverse)
      romAddr = ROMA_W'(QDEPTH - 1) - {1'b0, foldCtrl.fineIdx};
    else
      romAddr = {1'b0, foldCtrl.fineIdx};
  end

  sinegen_qrom u_qrom (
    .romAddr (romAddr),
    .romData (romData)
  );

  // Reflect the amplitude about the midline for the negative lobe
  always_comb begin
    if (foldCtrl.forceMid)    foldedVal = MIDLINE;
    else if (foldCtrl.invert) foldedVal = FULLSCALE - romData;
    else                      foldedVal = romData;
  end

  always_ff @(posedge clk) begin
    if (rst)                foldedValReg_reset();
    else if (foldCtrl.load) sampleOut <= foldedVal;
  end

  task automatic foldedValReg_reset();
    sampleOut <= MIDLINE;
  endtask

endmodule

// File: rtl/sine_quarter_gen.sv
module sine_quarter_gen
  import sinegen_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  logic [PHASE_W-1:0]  stepSize,
  output logic [SAMPLE_W-1:0] sampleOut,
  output logic                sampleValid
);

  foldCtrl_t foldCtrl;

  sinegen_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .stepSize    (stepSize),
    .foldCtrl    (foldCtrl),
    .sampleValid (sampleValid)
  );

  sinegen_dpath u_dpath (
    .clk       (clk),
    .rst       (rst),
    .foldCtrl  (foldCtrl),
    .sampleOut (sampleOut)
  );

endmodule

// File: rtl/sinegen_checker.sv
module sinegen_checker
  import sinegen_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                enable,
  input logic [PHASE_W-1:0]  stepSize,
  input logic [SAMPLE_W-1:0] sampleOut,
  input logic                sampleValid
);

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (sampleOut == MIDLINE && !sampleValid)); // R1

  AST_VALID_ON_ENABLE: assert property (@(posedge clk) disable iff (rst)
    enable |=> sampleValid); // R2

  AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !sampleValid); // R2

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !enable |=> $stable(sampleOut)); // R3

  AST_ZERO_STEP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (enable && stepSize == '0) ##1 (enable && stepSize == '0) |=> $stable(sampleOut)); // R9

endmodule

bind sine_quarter_gen sinegen_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .enable      (enable),
  .stepSize    (stepSize),
  .sampleOut   (sampleOut),
  .sampleValid (sampleValid)
);

// File: tb/sim_sine_quarter_gen.sv
module sim_sine_quarter_gen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b0;
  logic [4:0] stepSize = 5'd1;
  logic [7:0] sampleOut;
  logic       sampleValid;

  int checks = 0;
  int errors = 0;

  // Full-period expected waveform
  int refTable [32] = '{128,152,176,198,218,234,245,253,
                        255,253,245,234,218,198,176,152,
                        128,103, 79, 57, 37, 21, 10,  2,
                          0,  2, 10, 21, 37, 57, 79,103};

  int    refPhase = 0;
  int    expSample = 128;
  int    expValid = 0;
  string modelTag = "R1";
  bit    capture = 1'b0;
  int    seenQ[$];

  sine_quarter_gen u0 (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .stepSize    (stepSize),
    .sampleOut   (sampleOut),
    .sampleValid (sampleValid)
  );

  always #5 clk = ~clk;

  task automatic checkOne(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    if (rst) begin
      expSample = 128; expValid = 0; refPhase = 0; modelTag = "R1";
    end else if (enable) begin
      expSample = refTable[refPhase];
      if (refPhase < 8)       modelTag = "R4 R5";
      else if (refPhase < 16) modelTag = "R4 R6";
      else if (refPhase == 16) modelTag = "R4 R8";
      else                    modelTag = "R4 R7";
      refPhase = (refPhase + int'(stepSize)) % 32;
      expValid = 1;
    end else begin
      expValid = 0; modelTag = "R3";
    end
  end

  // Compare away from the active edge
  always @(negedge clk) begin
    checkOne("R2 valid", int'(sampleValid), expValid);
    checkOne(modelTag, int'(sampleOut), expSample);
    if (capture && sampleValid) seenQ.push_back(int'(sampleOut));
  end

  task automatic runCycles(input bit en, input int step, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      enable   = en;
      stepSize = 5'(step);
    end
  endtask

  initial begin
    int held;
    runCycles(1'b0, 1, 3);
    @(negedge clk); rst = 1'b0;
    // R1: still reset state before any enable
    checkOne("R1 reset sample", int'(sampleOut), 128);
    checkOne("R1 reset valid", int'(sampleValid), 0);

    // R10: step 1 over more than two periods
    capture = 1'b1;
    runCycles(1'b1, 1, 70);
    @(negedge clk); enable = 1'b0;
    capture = 1'b0;
    @(negedge clk);
    checkOne("R1 first sample", seenQ[0], 128);
    checkOne("R10 repeat 0/32", seenQ[0], seenQ[32]);
    checkOne("R10 repeat 8/40", seenQ[8], seenQ[40]);
    checkOne("R6 peak at 8", seenQ[8], 255);
    checkOne("R8 mid at 16", seenQ[16], 128);

    // R3: idle gap holds the sample
    held = int'(sampleOut);
    runCycles(1'b0, 7, 5);
    @(negedge clk);
    checkOne("R3 idle hold", int'(sampleOut), held);

    runCycles(1'b1, 3, 70);
    runCycles(1'b0, 3, 3);
    runCycles(1'b1, 8, 20);

    // R9: zero step
    runCycles(1'b1, 0, 2);
    @(negedge clk);
    held = int'(sampleOut);
    runCycles(1'b1, 0, 4);
    @(negedge clk);
    checkOne("R9 zero step hold", int'(sampleOut), held);

    runCycles(1'b1, 31, 40);
    for (int i = 0; i < 30; i++) runCycles(i[0], 5, 1);

    // R1: reset in the middle of a sweep
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; enable = 1'b0;
    checkOne("R1 mid-run reset", int'(sampleOut), 128);
    runCycles(1'b1, 1, 10);
    runCycles(1'b0, 1, 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule